// File: doc/BRIEF.md
# Global-History Hashed Branch Direction Predictor

This block guesses whether a conditional branch will be taken, so that fetch can continue down the guessed path without waiting for the branch to resolve. It keeps a register of recent real branch outcomes. It XORs that history with the word-address bits of the fetch PC and uses the result to pick one entry in a table of two-bit saturating counters. The upper bit of the chosen counter is the guess. Because the history takes part in the index, the same branch can land on different counters depending on how the branches before it went. This lets the block learn outcomes that depend on other branches.

Lookup is purely combinational. In one cycle the block takes a fetch PC and returns both the guess and the table index it used. The pipeline keeps that index alongside the branch. When the branch resolves, the pipeline presents the index and the real outcome on the update port. At the next clock edge the chosen counter is trained and the outcome is shifted into the history. The block predicts direction only. It does not predict branch targets, and it does not repair history after a misprediction.

Top module: `gshare_predictor`

## Requirements
- R1: The lookup index equals PC bits [IDX_W+1:2] XOR the history register, with the two low PC bits ignored. A branch that strictly alternates, or that repeats a fixed short loop pattern, is predicted without error once trained.
- R2: When no update targets the same entry in that cycle, the prediction is taken (1) exactly when the selected counter is 2'b10 or 2'b11.
- R3: After reset, every counter holds 2'b01 (weakly not-taken) and the history is all zeros. Every lookup therefore predicts not-taken, and the index equals the PC bits alone.
- R4: A taken update increments the addressed counter, and the counter stops at 2'b11.
- R5: A not-taken update decrements the addressed counter, and the counter stops at 2'b00.
- R6: Each update shifts the real outcome into history bit 0, moves the older bits up by one place, and drops the oldest bit.
- R7: An update changes only the entry at its own supplied index, whatever index the lookup uses in the same cycle.
- R8: When an update and a lookup select the same entry in one cycle, the prediction is taken from the counter value after that update.
- R9: While the update valid input is low, neither the counters nor the history change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Fetch PC to predict |
| lk_taken | output | 1 | Guess: 1 = taken |
| lk_idx | output | IDX_W | Table index used for this lookup |
| upd_valid | input | 1 | A resolved branch is being reported |
| upd_idx | input | IDX_W | Index captured when that branch was looked up |
| upd_taken | input | 1 | Real outcome: 1 = taken |

## Verification
Every cycle, the assertions check four things. The index is the XOR of the PC with the live history. With no colliding update, the guess follows the raw counter's upper bit. The history shifts correctly on an update and holds without one. A same-entry update moves the guess in the outcome's direction unless the counter sits at the opposite end. Saturation at both ends, reset contents, and the isolation of other entries can only be seen through the bench's scenarios, which compare every lookup with a reference model. The same is true of whether alternating and loop branches are learned.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_RESET = 2'b01;

    // Saturating two-bit counter step: up on taken, down on not-taken.
    function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
        ctr_t r;
        r = c;
        if (taken && c != 2'b11)
            r = c + 2'b01;
        else if (!taken && c != 2'b00)
            r = c - 2'b01;
        return r;
    endfunction

endpackage

// File: rtl/gshare_hash.sv
module gshare_hash #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 10
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [IDX_W-1:0] hist,
    output logic [IDX_W-1:0] idx
);
    localparam int LO = 2;
    localparam int HI = IDX_W + LO - 1;

    always_comb begin
        idx = pc[HI:LO] ^ hist;
    end
endmodule

// File: rtl/gshare_hist.sv
module gshare_hist #(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             shift_bit,
    output logic [IDX_W-1:0] hist
);
    typedef struct packed {
        logic [IDX_W-1:0] bits;
    } hist_state_t;

    hist_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en)
            st_d.bits = {st_q.bits[IDX_W-2:0], shift_bit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign hist = st_q.bits;
endmodule

// File: rtl/gshare_pht.sv
module gshare_pht
    import gshare_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken,
    output ctr_t             rd_raw,
    output ctr_t             rd_cnt
);
    localparam int ENTRIES = 1 << IDX_W;

    ctr_t cnt_all [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        ctr_t cnt_d, cnt_q;

        always_comb begin
            cnt_d = cnt_q;
            if (wr_en && wr_idx == IDX_W'(e))
                cnt_d = ctr_step(cnt_q, wr_taken);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cnt_q <= CTR_RESET;
            else
                cnt_q <= cnt_d;
        end

        assign cnt_all[e] = cnt_q;
    end

    always_comb begin
        rd_raw = cnt_all[rd_idx];
        rd_cnt = rd_raw;
        // A same-entry update wins: forward its result to the reader.
        if (wr_en && wr_idx == rd_idx)
            rd_cnt = ctr_step(rd_raw, wr_taken);
    end
endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
    import gshare_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  lk_pc,
    output logic             lk_taken,
    output logic [IDX_W-1:0] lk_idx,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_taken
);
    logic [IDX_W-1:0] ghr_q;
    ctr_t             rd_raw;
    ctr_t             rd_cnt;

    gshare_hash #(.PC_W(PC_W), .IDX_W(IDX_W)) u_hash (
        .pc   (lk_pc),
        .hist (ghr_q),
        .idx  (lk_idx)
    );

    gshare_hist #(.IDX_W(IDX_W)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (upd_valid),
        .shift_bit (upd_taken),
        .hist      (ghr_q)
    );

    gshare_pht #(.IDX_W(IDX_W)) u_pht (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .wr_en    (upd_valid),
        .wr_idx   (upd_idx),
        .wr_taken (upd_taken),
        .rd_raw   (rd_raw),
        .rd_cnt   (rd_cnt)
    );

    assign lk_taken = rd_cnt[1];
endmodule

// File: rtl/gshare_checker.sv
module gshare_checker #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PC_W-1:0]  lk_pc,
    input logic             lk_taken,
    input logic [IDX_W-1:0] lk_idx,
    input logic             upd_valid,
    input logic [IDX_W-1:0] upd_idx,
    input logic             upd_taken,
    input logic [IDX_W-1:0] hist,
    input logic [1:0]       raw_cnt
);
    logic hit;
    assign hit = upd_valid && (upd_idx == lk_idx);

    assert_idx_hash_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_idx ^ lk_pc[IDX_W+1:2]) == hist);

    assert_pred_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (lk_taken == raw_cnt[1]));

    assert_hist_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (hist == {$past(hist[IDX_W-2:0]), $past(upd_taken)}));

    assert_hist_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(hist));

    assert_fwd_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && upd_taken && raw_cnt != 2'b00) |-> lk_taken);

    assert_fwd_not_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !upd_taken && raw_cnt != 2'b11) |-> !lk_taken);
endmodule

bind gshare_predictor gshare_checker #(.PC_W(PC_W), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_pc     (lk_pc),
    .lk_taken  (lk_taken),
    .lk_idx    (lk_idx),
    .upd_valid (upd_valid),
    .upd_idx   (upd_idx),
    .upd_taken (upd_taken),
    .hist      (ghr_q),
    .raw_cnt   (rd_raw)
);

// File: tb/sim_gshare_predictor.sv
module sim_gshare_predictor;
    localparam int PC_W  = 32;
    localparam int IDX_W = 10;
    localparam int ENT   = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PC_W-1:0]  lk_pc = '0;
    logic             lk_taken;
    logic [IDX_W-1:0] lk_idx;
    logic             upd_valid = 1'b0;
    logic [IDX_W-1:0] upd_idx = '0;
    logic             upd_taken = 1'b0;

    always #2 clk = ~clk;

    gshare_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) u0 (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
        .lk_idx(lk_idx), .upd_valid(upd_valid), .upd_idx(upd_idx),
        .upd_taken(upd_taken)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [1:0]       ref_cnt [ENT];
    logic [IDX_W-1:0] ref_hist;
    logic [IDX_W-1:0] got_idx;
    logic             got_pred;

    function automatic logic [1:0] sat(input logic [1:0] c, input logic t);
        if (t) return (c == 2'b11) ? c : c + 2'b01;
        return (c == 2'b00) ? c : c - 2'b01;
    endfunction

    function automatic logic [PC_W-1:0] pc_for(input logic [IDX_W-1:0] want);
        return PC_W'(want ^ ref_hist) << 2;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; upd_valid = 1'b0;
        for (int i = 0; i < ENT; i++) ref_cnt[i] = 2'b01;
        ref_hist = '0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One cycle: drive lookup and update, check lookup, then advance the model.
    task automatic step(input logic [PC_W-1:0] pc, input logic uv,
                        input logic [IDX_W-1:0] ui, input logic ut, input string req);
        logic [IDX_W-1:0] e_idx;
        logic [1:0]       e_cnt;
        @(negedge clk);
        lk_pc = pc; upd_valid = uv; upd_idx = ui; upd_taken = ut;
        #1;
        e_idx = pc[IDX_W+1:2] ^ ref_hist;
        e_cnt = ref_cnt[e_idx];
        if (uv && ui == e_idx) e_cnt = sat(e_cnt, ut);
        check(lk_idx == e_idx, req, "index", int'(lk_idx), int'(e_idx));
        check(lk_taken == e_cnt[1], req, "prediction", int'(lk_taken), int'(e_cnt[1]));
        got_idx = lk_idx; got_pred = lk_taken;
        @(posedge clk);
        if (uv) begin
            ref_cnt[ui] = sat(ref_cnt[ui], ut);
            ref_hist = {ref_hist[IDX_W-2:0], ut};
        end
    endtask

    // One branch resolved one cycle after its lookup; kind 0 alternates, 1 = loop of 4.
    task automatic run_pattern(input logic [PC_W-1:0] pc, input int kind,
                               input int iters, input int warm, input string req);
        logic             pv = 1'b0;
        logic [IDX_W-1:0] pi = '0;
        logic             po = 1'b0;
        int               miss = 0;
        for (int k = 0; k < iters; k++) begin
            logic outc;
            outc = (kind == 0) ? logic'(k % 2) : logic'((k % 4) != 3);
            step(pc, pv, pi, po, req);
            if (k >= warm && got_pred != outc) miss++;
            pv = 1'b1; pi = got_idx; po = outc;
        end
        step(pc, pv, pi, po, req);
        check(miss == 0, req, "trained mispredicts", miss, 0);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [IDX_W-1:0] x;
        void'($urandom(32'd20240611));
        do_reset();

        // R3: reset state seen through lookups only
        for (int i = 0; i < 8; i++) begin
            logic [PC_W-1:0] p;
            p = $urandom;
            step(p, 1'b0, '0, 1'b0, "R3");
            check(got_idx == p[IDX_W+1:2], "R3", "reset index", int'(got_idx), int'(p[IDX_W+1:2]));
            check(got_pred == 1'b0, "R3", "reset prediction", int'(got_pred), 0);
        end

        // R4 and R8: drive one entry up past saturation while looking it up
        x = 10'h155;
        for (int i = 0; i < 5; i++) step(pc_for(x), 1'b1, x, 1'b1, "R8");
        step(pc_for(x), 1'b1, x, 1'b0, "R4");
        step(pc_for(x), 1'b0, '0, 1'b0, "R4");
        check(got_pred == 1'b1, "R4", "after saturate then one down", int'(got_pred), 1);

        // R5: drive down past saturation
        for (int i = 0; i < 5; i++) step(pc_for(x), 1'b1, x, 1'b0, "R5");
        step(pc_for(x), 1'b1, x, 1'b1, "R5");
        step(pc_for(x), 1'b0, '0, 1'b0, "R5");
        check(got_pred == 1'b0, "R5", "after floor then one up", int'(got_pred), 0);

        // R7: update one entry while looking up another, then read both
        step(pc_for(10'h0f0), 1'b1, 10'h00f, 1'b1, "R7");
        step(pc_for(10'h0f0), 1'b1, 10'h00f, 1'b1, "R7");
        step(pc_for(10'h0f0), 1'b0, '0, 1'b0, "R7");
        check(got_pred == 1'b0, "R7", "untouched entry", int'(got_pred), 0);
        step(pc_for(10'h00f), 1'b0, '0, 1'b0, "R7");
        check(got_pred == 1'b1, "R7", "written entry", int'(got_pred), 1);

        // R9: idle cycles leave all state alone
        for (int i = 0; i < 20; i++) step($urandom, 1'b0, 10'($urandom), 1'b1, "R9");
        step(pc_for(10'h00f), 1'b0, '0, 1'b0, "R9");
        check(got_pred == 1'b1, "R9", "entry kept over idle", int'(got_pred), 1);

        // R1: history correlation learns alternating and loop branches
        do_reset();
        run_pattern(32'h0000_4a10, 0, 80, 40, "R1");
        do_reset();
        run_pattern(32'h0000_81c4, 1, 160, 100, "R1");

        // R2 and R6: random mix of lookups and updates against the model
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            logic uv;
            logic [IDX_W-1:0] ui;
            uv = ($urandom % 4) != 0;
            ui = (($urandom % 3) == 0) ? 10'($urandom % 8) : 10'($urandom);
            step(($urandom % 2) ? PC_W'($urandom % 64) : PC_W'($urandom), uv, ui,
                 logic'($urandom % 2), (i % 2) ? "R2" : "R6");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule